// File: doc/BRIEF.md
# Sixteen-Slot 12-bit Colour Lookup

This block holds sixteen colour slots, each with four bits of red, four of green and four of blue. Together they span 4096 colours. The host loads a slot through one write-only I/O port of a 16-bit address bus. The low address byte decodes the port. Address bits 12:9 pick the slot, and address bit 8 picks which components the 8-bit data bus carries. One write loads either red and blue together or green alone.

On the video side, a 4-bit pixel index is looked up to give a registered 12-bit RGB word. An active-low select input chooses between that palette colour and a pass-through main video word, so the downstream DAC sees one source or the other. The select and the pass-through word are registered in the same stage as the lookup. Both sources therefore reach the output with the same latency.

Top module: `clut_palette`

## Requirements
- R1: While reset is asserted, `rgb_out` is 0. After reset, slot n holds red = green = blue = n, which gives a grey ramp.
- R2: A write with address bit 8 = 0 loads the addressed slot as follows: blue from data bits 3:0 and red from data bits 7:4. Green is kept.
- R3: A write with address bit 8 = 1 loads the addressed slot's green from data bits 3:0. Red, blue and data bits 7:4 have no effect.
- R4: Address bits 12:9 give the slot number. Address bits 15:13 are ignored, and no other slot changes.
- R5: A write takes effect only at a rising clock edge where `io_wr` is high and `io_addr[7:0]` equals `PORT_ADDR` (default 0xAE). Any other cycle leaves all slots unchanged.
- R6: The output word is `{red[11:8], green[7:4], blue[3:0]}`. It appears one clock after `pix_idx` is sampled and holds until the next edge.
- R7: When `pal_sel_n` = 1, `rgb_out` carries `main_rgb` sampled one clock earlier. When it is 0, `rgb_out` carries the palette colour. The select has the same one-clock latency.
- R8: When a lookup and a write hit the same slot at the same edge, the output shows the slot's old colour. The new colour appears from the next lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the write port and the video path |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_addr | input | 16 | I/O address: low byte decodes the port, bits 12:9 select the slot, bit 8 selects the component |
| io_data | input | 8 | Write data: blue or green on bits 3:0, red on bits 7:4 |
| pix_idx | input | 4 | Pixel colour index to look up |
| main_rgb | input | 12 | Main-unit video word to pass through |
| pal_sel_n | input | 1 | 0 selects the palette, 1 selects the main-unit video |
| rgb_out | output | 12 | Registered RGB video word |

## Verification
A host write and a pixel lookup can land on the same slot at the same clock edge. That is the one case where the store and the video path interact. The bench provokes it by driving a write strobe and a matching `pix_idx` together, once for each component selector. It then checks that the output first shows the pre-write colour and shows the merged colour on the following lookup. The bench also sweeps every slot with both selector values and with varied ignored upper address bits, reading all sixteen slots back after each phase to confirm that no write leaked into another slot.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CW    = 4;
  localparam int RGB_W = 3 * CW;
  localparam int AW    = 16;
  localparam int DW    = 8;
  localparam int SLOT_LSB = 9;
  localparam int GSEL_BIT = 8;

  typedef logic [RGB_W-1:0] rgb_t;

  // Reset colour for a slot: all three components equal the slot number.
  function automatic rgb_t grey_of(input int n);
    logic [CW-1:0] c;
    c = CW'(n);
    return {c, c, c};
  endfunction

  // New slot contents after one host write.
  function automatic rgb_t merge_write(input rgb_t old, input logic [DW-1:0] d,
                                       input logic gsel);
    rgb_t r;
    r = old;
    if (gsel) begin
      r[2*CW-1:CW] = d[CW-1:0];
    end else begin
      r[3*CW-1:2*CW] = d[2*CW-1:CW];
      r[CW-1:0]      = d[CW-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/clut_wdec.sv
module clut_wdec #(
  parameter logic [7:0] PORT_ADDR = 8'hAE,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [15:0]      io_addr,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_grn
);
  import clut_pkg::*;

  logic port_hit;

  assign port_hit = (io_addr[7:0] == PORT_ADDR);
  assign wr_en    = io_wr && port_hit;
  assign wr_idx   = io_addr[SLOT_LSB +: IDX_W];
  assign wr_grn   = io_addr[GSEL_BIT];

  // R5: another port address never produces a write
  a_r5_port_only: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr[7:0] != PORT_ADDR) |-> !wr_en);

  // R5: no write without the strobe
  a_r5_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |-> !wr_en);
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_grn,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output clut_pkg::rgb_t   rd_rgb,
  output clut_pkg::rgb_t   tgt_old
);
  import clut_pkg::*;

  rgb_t ent [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    rgb_t q;
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= grey_of(g);
      else if (hit) q <= merge_write(q, wr_data, wr_grn);
    end
    assign ent[g] = q;
  end

  assign rd_rgb  = ent[rd_idx];
  assign tgt_old = ent[wr_idx];

  // R2: red and blue come from the data byte
  a_r2_rb_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_grn) |=>
      (ent[$past(wr_idx)][3*CW-1:2*CW] == $past(wr_data[2*CW-1:CW])) &&
      (ent[$past(wr_idx)][CW-1:0] == $past(wr_data[CW-1:0])));

  // R2: green survives a red/blue write
  a_r2_grn_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_grn) |=>
      ent[$past(wr_idx)][2*CW-1:CW] == $past(tgt_old[2*CW-1:CW]));

  // R3: a green write keeps red and blue
  a_r3_rb_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grn) |=>
      (ent[$past(wr_idx)][3*CW-1:2*CW] == $past(tgt_old[3*CW-1:2*CW])) &&
      (ent[$past(wr_idx)][CW-1:0] == $past(tgt_old[CW-1:0])));

  // R3: green comes from the low data nibble
  a_r3_grn_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_grn) |=>
      ent[$past(wr_idx)][2*CW-1:CW] == $past(wr_data[CW-1:0]));
endmodule

// File: rtl/clut_vout.sv
module clut_vout (
  input  logic           clk,
  input  logic           rst_n,
  input  clut_pkg::rgb_t pal_rgb,
  input  clut_pkg::rgb_t main_rgb,
  input  logic           sel_n,
  output clut_pkg::rgb_t rgb_out
);
  import clut_pkg::*;

  rgb_t out_q;
  logic live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      live_q <= 1'b0;
    end else begin
      out_q  <= sel_n ? main_rgb : pal_rgb;
      live_q <= 1'b1;
    end
  end

  assign rgb_out = out_q;

  // R6: palette colour appears one clock after lookup
  a_r6_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !$past(sel_n)) |-> rgb_out == $past(pal_rgb));

  // R7: pass-through path has the same latency
  a_r7_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(sel_n)) |-> rgb_out == $past(main_rgb));
endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
  parameter int         N_ENT     = 16,
  parameter logic [7:0] PORT_ADDR = 8'hAE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_data,
  input  logic [3:0]  pix_idx,
  input  logic [11:0] main_rgb,
  input  logic        pal_sel_n,
  output logic [11:0] rgb_out
);
  import clut_pkg::*;

  localparam int IDX_W = $clog2(N_ENT);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_grn;
  rgb_t             rd_rgb;
  rgb_t             tgt_old;
  rgb_t             vo_rgb;
  logic             same_slot;

  clut_wdec #(.PORT_ADDR(PORT_ADDR), .IDX_W(IDX_W)) u_wdec (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_grn(wr_grn)
  );

  clut_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_grn(wr_grn), .wr_data(io_data), .rd_idx(pix_idx[IDX_W-1:0]),
    .rd_rgb(rd_rgb), .tgt_old(tgt_old)
  );

  clut_vout u_vout (
    .clk(clk), .rst_n(rst_n), .pal_rgb(rd_rgb), .main_rgb(main_rgb),
    .sel_n(pal_sel_n), .rgb_out(vo_rgb)
  );

  assign rgb_out = vo_rgb;

  // Lookup and write collide on one slot in this cycle
  assign same_slot = wr_en && (wr_idx == pix_idx[IDX_W-1:0]);

  // R8: a colliding lookup returns the pre-write colour
  a_r8_old_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (same_slot && !pal_sel_n) |=> rgb_out == $past(tgt_old));
endmodule

// File: tb/sim_clut_palette.sv
module sim_clut_palette;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [15:0] io_addr;
  logic [7:0]  io_data;
  logic [3:0]  pix_idx;
  logic [11:0] main_rgb;
  logic        pal_sel_n;
  logic [11:0] rgb_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] model [16];

  always #2 clk = ~clk;

  clut_palette u0 (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_data(io_data), .pix_idx(pix_idx), .main_rgb(main_rgb),
    .pal_sel_n(pal_sel_n), .rgb_out(rgb_out)
  );

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] mk_addr(input int up, input int slot, input bit g,
                                          input logic [7:0] lo);
    logic [2:0] u;
    logic [3:0] s;
    u = 3'(up);
    s = 4'(slot);
    return {u, s, g, lo};
  endfunction

  // Model of one write: green sits at bits 7:4, red at 11:8, blue at 3:0
  function automatic logic [11:0] upd(input logic [11:0] old, input logic [15:0] a,
                                      input logic [7:0] d);
    if (a[8]) return (old & 12'hF0F) | (12'(d % 16) * 12'd16);
    return (old & 12'h0F0) | (12'(d / 16) * 12'd256) | 12'(d % 16);
  endfunction

  task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_data = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic look(input int idx, input string req);
    @(negedge clk);
    pix_idx = 4'(idx); pal_sel_n = 1'b0;
    @(negedge clk);
    chk(req, rgb_out, model[idx]);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) look(i, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    logic [11:0] old;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = '0; io_data = '0;
    pix_idx = '0; main_rgb = 12'hABC; pal_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset output", rgb_out, 12'h000);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) model[i] = 12'(i * 12'h111);
    sweep("R1 grey ramp");

    // R2 / R3 / R4: every slot, both selectors, ignored upper bits varied
    for (int e = 0; e < 16; e++) begin
      a = mk_addr(e * 3 + 1, e, 1'b0, 8'hAE);
      d = 8'(e * 37 + 11);
      host_wr(a, d);
      model[e] = upd(model[e], a, d);
      look(e, "R2 red/blue write");
      a = mk_addr(7 - (e % 8), e, 1'b1, 8'hAE);
      d = 8'(e * 53 + 200);
      host_wr(a, d);
      model[e] = upd(model[e], a, d);
      look(e, "R3 green write");
    end
    sweep("R4 slot isolation");

    // R5: wrong port addresses and a matching address without strobe
    host_wr(mk_addr(0, 3, 1'b0, 8'hAF), 8'h00);
    host_wr(mk_addr(0, 5, 1'b1, 8'hAD), 8'hFF);
    host_wr(mk_addr(0, 9, 1'b0, 8'h00), 8'h77);
    @(negedge clk);
    io_addr = mk_addr(0, 12, 1'b0, 8'hAE); io_data = 8'h33; io_wr = 1'b0;
    @(negedge clk);
    sweep("R5 no stray write");

    // R7: pass-through of the main video word
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      main_rgb = 12'(k * 12'h1A7 + 3); pal_sel_n = 1'b1; pix_idx = 4'(k);
      @(negedge clk);
      chk("R7 main pass", rgb_out, 12'(k * 12'h1A7 + 3));
    end

    // R6: one-clock latency for index and select changes
    @(negedge clk);
    pix_idx = 4'd2; pal_sel_n = 1'b0;
    @(negedge clk);
    chk("R6 lookup", rgb_out, model[2]);
    pix_idx = 4'd9;
    #1 chk("R6 hold before edge", rgb_out, model[2]);
    @(negedge clk);
    chk("R6 new index", rgb_out, model[9]);
    pal_sel_n = 1'b1; main_rgb = 12'h5E1;
    #1 chk("R7 select latency", rgb_out, model[9]);
    @(negedge clk);
    chk("R7 select switched", rgb_out, 12'h5E1);

    // R8: write and lookup on the same slot in one cycle, both selectors
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      a = mk_addr(2, 6 + s, s[0], 8'hAE);
      d = 8'h5A + 8'(s * 17);
      old = model[6 + s];
      pix_idx = 4'(6 + s); pal_sel_n = 1'b0;
      io_addr = a; io_data = d; io_wr = 1'b1;
      @(negedge clk);
      chk("R8 old colour", rgb_out, old);
      io_wr = 1'b0;
      model[6 + s] = upd(old, a, d);
      @(negedge clk);
      chk("R8 new colour", rgb_out, model[6 + s]);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule